// File: doc/BRIEF.md
# Window-to-Head Assignment Resolver

This block turns a packed window-to-head assignment word into a ready-to-use routing result for a display pipeline. Each window owns one byte of the word, and one set bit in that byte names the head the window feeds. The resolver checks the word against the number of windows and heads the hardware provides. It works out which heads survive culling and reports, for every window, whether it is enabled and which head it drives. When no assignment word is supplied, the block falls back to a fixed pairing of two windows per head.

A one-cycle `start_i` pulse begins a run. The block latches the word, the presence flag and both hardware counts in that cycle, so later changes to those inputs do not reach the result. It then visits one window per clock and publishes the result together with a one-cycle `done_o` pulse. All control and status pins are plain levels or pulses, and there is no back-pressure. The published result holds until the next run completes. While a run is in progress the block drops any further `start_i` pulse.

Top module: `win_head_resolver`

## Requirements
- R1: Window w owns bits [8w+7:8w] of `assign_mask_i`, and bit h of that byte selects head h. `win_head_o[3w+2:3w]` reports the selected head for an enabled window and reads 0 for a disabled one.
- R2: `done_o` is a one-cycle pulse on the 9th rising edge after the edge that accepts `start_i`. A `start_i` seen before that pulse is ignored. The result outputs change only on the `done_o` edge.
- R3: With `mask_present_i` low, the effective byte of window w is (1 << w/2) when w < `hw_win_count_i` and w/2 < `hw_head_count_i`, and 0 otherwise.
- R4: A nonzero byte on a window at or above `hw_win_count_i` sets `err_flags_o[1]`.
- R5: A set bit at a head position at or above `hw_head_count_i`, in the byte of a supported window, sets `err_flags_o[2]`.
- R6: A byte of a supported window with more than one set bit sets `err_flags_o[3]`.
- R7: An effective word equal to zero sets `err_flags_o[0]`. More than one flag may be set in a single run.
- R8: `head_en_o[h]` is 1 exactly when h < `hw_head_count_i` and every head 0..h has at least one validly assigned window. The first empty head and all heads above it are culled.
- R9: A window whose head is culled reports `win_en_o` low. Culling alone does not make the result an error, so `valid_o` stays 1.
- R10: When any error flag is set, `error_o` is 1, `valid_o` is 0, and `win_en_o`, `head_en_o` and `win_head_o` are all zero. Otherwise `valid_o` is 1 and `error_o` is 0.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when the block is idle |
| mask_present_i | input | 1 | 1 = use `assign_mask_i`; 0 = use the default pairing |
| assign_mask_i | input | 64 | One head byte per window |
| hw_win_count_i | input | 4 | Number of windows the hardware supports (0..8) |
| hw_head_count_i | input | 4 | Number of heads the hardware supports (0..8) |
| done_o | output | 1 | One-cycle pulse when a result is published |
| valid_o | output | 1 | Last result is a legal assignment |
| error_o | output | 1 | Last result was rejected |
| err_flags_o | output | 4 | Rejection causes: [0] empty, [1] window, [2] head, [3] multi-head |
| win_en_o | output | 8 | Per-window enable |
| win_head_o | output | 24 | Per-window head index, 3 bits each |
| head_en_o | output | 8 | Active heads after culling |

## Verification
Every result output and `done_o` is due on the 9th rising edge after the accepting edge: one edge latches the inputs, eight edges scan the windows, and one edge registers the result. The bench counts edges from the accepting edge and samples on falling edges. It requires `done_o` to be low for the first eight samples, high on the ninth, and low again on the tenth. Result values are checked in the same sample as the `done_o` pulse. For the hold and ignored-start cases, the outputs are sampled again several cycles after inputs change.

// File: rtl/whr_pkg.sv
package whr_pkg;

  typedef enum logic [1:0] {
    WHR_IDLE  = 2'd0,
    WHR_SCAN  = 2'd1,
    WHR_FINAL = 2'd2
  } whr_state_e;

  localparam int ERR_W       = 4;
  localparam int ERR_EMPTY   = 0;
  localparam int ERR_WINDOW  = 1;
  localparam int ERR_HEAD    = 2;
  localparam int ERR_MULTI   = 3;

endpackage

// File: rtl/whr_scan_ctrl.sv
module whr_scan_ctrl #(
  parameter int NUM_WIN   = 8,
  parameter int WIN_CNT_W = $clog2(NUM_WIN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  output logic                 accept_o,
  output logic                 scan_o,
  output logic [WIN_CNT_W-1:0] idx_o,
  output logic                 final_o
);
  import whr_pkg::*;

  localparam logic [WIN_CNT_W-1:0] LAST_IDX = WIN_CNT_W'(NUM_WIN - 1);

  whr_state_e           state_q;
  logic [WIN_CNT_W-1:0] idx_q;

  assign accept_o = (state_q == WHR_IDLE) && start_i;
  assign scan_o   = (state_q == WHR_SCAN);
  assign final_o  = (state_q == WHR_FINAL);
  assign idx_o    = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WHR_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        WHR_IDLE: begin
          if (start_i) begin
            state_q <= WHR_SCAN;
            idx_q   <= '0;
          end
        end
        WHR_SCAN: begin
          if (idx_q == LAST_IDX) begin
            state_q <= WHR_FINAL;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        WHR_FINAL: state_q <= WHR_IDLE;
        default:   state_q <= WHR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/whr_byte_eval.sv
module whr_byte_eval #(
  parameter int HEAD_BITS  = 8,
  parameter int WIN_CNT_W  = 4,
  parameter int HEAD_CNT_W = $clog2(HEAD_BITS + 1),
  parameter int HEAD_IDX_W = (HEAD_BITS > 1) ? $clog2(HEAD_BITS) : 1
) (
  input  logic [HEAD_BITS-1:0]  byte_i,
  input  logic [WIN_CNT_W-1:0]  win_idx_i,
  input  logic [WIN_CNT_W-1:0]  hw_win_i,
  input  logic [HEAD_CNT_W-1:0] hw_head_i,
  output logic                  win_bad_o,
  output logic                  head_bad_o,
  output logic                  multi_o,
  output logic                  good_o,
  output logic [HEAD_IDX_W-1:0] head_idx_o,
  output logic [HEAD_BITS-1:0]  head_hot_o
);

  logic                 nonzero;
  logic                 win_ok;
  logic [HEAD_BITS-1:0] out_of_range;

  always_comb begin
    for (int h = 0; h < HEAD_BITS; h++) begin
      out_of_range[h] = !(HEAD_CNT_W'(h) < hw_head_i);
    end
  end

  always_comb begin
    head_idx_o = '0;
    for (int h = HEAD_BITS - 1; h >= 0; h--) begin
      if (byte_i[h]) head_idx_o = HEAD_IDX_W'(h);
    end
  end

  assign nonzero    = |byte_i;
  assign win_ok     = win_idx_i < hw_win_i;
  assign win_bad_o  = nonzero && !win_ok;
  assign head_bad_o = win_ok && (|(byte_i & out_of_range));
  assign multi_o    = win_ok && (|(byte_i & (byte_i - 1'b1)));
  assign good_o     = nonzero && win_ok && !head_bad_o && !multi_o;
  assign head_hot_o = good_o ? byte_i : '0;

endmodule

// File: rtl/whr_cull.sv
module whr_cull #(
  parameter int HEAD_BITS  = 8,
  parameter int HEAD_CNT_W = $clog2(HEAD_BITS + 1)
) (
  input  logic [HEAD_BITS-1:0]  occupied_i,
  input  logic [HEAD_CNT_W-1:0] hw_head_i,
  output logic [HEAD_BITS-1:0]  head_en_o
);

  logic [HEAD_BITS-1:0] live;

  always_comb begin
    for (int h = 0; h < HEAD_BITS; h++) begin
      live[h] = occupied_i[h] && (HEAD_CNT_W'(h) < hw_head_i);
    end
  end

  generate
    for (genvar h = 0; h < HEAD_BITS; h++) begin : g_prefix
      if (h == 0) begin : g_first
        assign head_en_o[h] = live[h];
      end else begin : g_rest
        assign head_en_o[h] = head_en_o[h-1] && live[h];
      end
    end
  endgenerate

endmodule

// File: rtl/win_head_resolver.sv
module win_head_resolver #(
  parameter int NUM_WIN    = 8,
  parameter int HEAD_BITS  = 8,
  parameter int MASK_W     = NUM_WIN * HEAD_BITS,
  parameter int WIN_CNT_W  = $clog2(NUM_WIN + 1),
  parameter int HEAD_CNT_W = $clog2(HEAD_BITS + 1),
  parameter int HEAD_IDX_W = (HEAD_BITS > 1) ? $clog2(HEAD_BITS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          mask_present_i,
  input  logic [MASK_W-1:0]             assign_mask_i,
  input  logic [WIN_CNT_W-1:0]          hw_win_count_i,
  input  logic [HEAD_CNT_W-1:0]         hw_head_count_i,
  output logic                          done_o,
  output logic                          valid_o,
  output logic                          error_o,
  output logic [3:0]                    err_flags_o,
  output logic [NUM_WIN-1:0]            win_en_o,
  output logic [NUM_WIN*HEAD_IDX_W-1:0] win_head_o,
  output logic [HEAD_BITS-1:0]          head_en_o
);
  import whr_pkg::*;

  localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  // ---------------- control ----------------
  logic                 accept;
  logic                 scanning;
  logic                 finishing;
  logic [WIN_CNT_W-1:0] scan_idx;

  whr_scan_ctrl #(
    .NUM_WIN   (NUM_WIN),
    .WIN_CNT_W (WIN_CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .scan_o   (scanning),
    .idx_o    (scan_idx),
    .final_o  (finishing)
  );

  // ---------------- default pairing ----------------
  logic [MASK_W-1:0] default_mask;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_default
      if ((w / 2) < HEAD_BITS) begin : g_pair
        localparam logic [WIN_CNT_W-1:0]  WV = WIN_CNT_W'(w);
        localparam logic [HEAD_CNT_W-1:0] HV = HEAD_CNT_W'(w / 2);
        assign default_mask[w*HEAD_BITS +: HEAD_BITS] =
          ((WV < hw_win_count_i) && (HV < hw_head_count_i)) ?
          HEAD_BITS'(1) << (w / 2) : '0;
      end else begin : g_none
        assign default_mask[w*HEAD_BITS +: HEAD_BITS] = '0;
      end
    end
  endgenerate

  // ---------------- latched run inputs ----------------
  logic [MASK_W-1:0]     mask_q;
  logic [WIN_CNT_W-1:0]  hw_win_q;
  logic [HEAD_CNT_W-1:0] hw_head_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      hw_win_q  <= '0;
      hw_head_q <= '0;
    end else if (accept) begin
      mask_q    <= mask_present_i ? assign_mask_i : default_mask;
      hw_win_q  <= hw_win_count_i;
      hw_head_q <= hw_head_count_i;
    end
  end

  // ---------------- per-window evaluation ----------------
  logic [HEAD_BITS-1:0]  cur_byte;
  logic                  cur_win_bad;
  logic                  cur_head_bad;
  logic                  cur_multi;
  logic                  cur_good;
  logic [HEAD_IDX_W-1:0] cur_head;
  logic [HEAD_BITS-1:0]  cur_hot;

  assign cur_byte = mask_q[int'(scan_idx) * HEAD_BITS +: HEAD_BITS];

  whr_byte_eval #(
    .HEAD_BITS  (HEAD_BITS),
    .WIN_CNT_W  (WIN_CNT_W),
    .HEAD_CNT_W (HEAD_CNT_W),
    .HEAD_IDX_W (HEAD_IDX_W)
  ) u_eval (
    .byte_i     (cur_byte),
    .win_idx_i  (scan_idx),
    .hw_win_i   (hw_win_q),
    .hw_head_i  (hw_head_q),
    .win_bad_o  (cur_win_bad),
    .head_bad_o (cur_head_bad),
    .multi_o    (cur_multi),
    .good_o     (cur_good),
    .head_idx_o (cur_head),
    .head_hot_o (cur_hot)
  );

  // ---------------- accumulation ----------------
  logic [HEAD_BITS-1:0]  occ_q;
  logic [ERR_W-1:0]      err_q;
  logic [NUM_WIN-1:0]    asg_q;
  logic [HEAD_IDX_W-1:0] head_q [NUM_WIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      err_q <= '0;
      asg_q <= '0;
      for (int w = 0; w < NUM_WIN; w++) head_q[w] <= '0;
    end else if (accept) begin
      occ_q <= '0;
      err_q <= '0;
      asg_q <= '0;
      for (int w = 0; w < NUM_WIN; w++) head_q[w] <= '0;
    end else if (scanning) begin
      occ_q             <= occ_q | cur_hot;
      err_q[ERR_WINDOW] <= err_q[ERR_WINDOW] | cur_win_bad;
      err_q[ERR_HEAD]   <= err_q[ERR_HEAD]   | cur_head_bad;
      err_q[ERR_MULTI]  <= err_q[ERR_MULTI]  | cur_multi;
      asg_q[scan_idx[WIN_IDX_W-1:0]]  <= cur_good;
      head_q[scan_idx[WIN_IDX_W-1:0]] <= cur_head;
    end
  end

  // ---------------- culling and final result ----------------
  logic [HEAD_BITS-1:0]          head_en_n;
  logic [ERR_W-1:0]              err_n;
  logic                          any_err;
  logic [NUM_WIN-1:0]            win_en_n;
  logic [NUM_WIN*HEAD_IDX_W-1:0] win_head_n;

  whr_cull #(
    .HEAD_BITS  (HEAD_BITS),
    .HEAD_CNT_W (HEAD_CNT_W)
  ) u_cull (
    .occupied_i (occ_q),
    .hw_head_i  (hw_head_q),
    .head_en_o  (head_en_n)
  );

  always_comb begin
    err_n            = err_q;
    err_n[ERR_EMPTY] = ~|mask_q;
    any_err          = |err_n;
    for (int w = 0; w < NUM_WIN; w++) begin
      win_en_n[w] = !any_err && asg_q[w] && head_en_n[head_q[w]];
      win_head_n[w*HEAD_IDX_W +: HEAD_IDX_W] = win_en_n[w] ? head_q[w] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      valid_o     <= 1'b0;
      error_o     <= 1'b0;
      err_flags_o <= '0;
      win_en_o    <= '0;
      win_head_o  <= '0;
      head_en_o   <= '0;
    end else begin
      done_o <= finishing;
      if (finishing) begin
        valid_o     <= !any_err;
        error_o     <= any_err;
        err_flags_o <= err_n;
        win_en_o    <= win_en_n;
        win_head_o  <= win_head_n;
        head_en_o   <= any_err ? '0 : head_en_n;
      end
    end
  end

endmodule

// File: rtl/whr_checker.sv
module whr_checker #(
  parameter int NUM_WIN    = 8,
  parameter int HEAD_BITS  = 8,
  parameter int HEAD_IDX_W = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          start_i,
  input logic                          done_o,
  input logic                          valid_o,
  input logic                          error_o,
  input logic [3:0]                    err_flags_o,
  input logic [NUM_WIN-1:0]            win_en_o,
  input logic [NUM_WIN*HEAD_IDX_W-1:0] win_head_o,
  input logic [HEAD_BITS-1:0]          head_en_o
);

  logic [3:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (run_cnt == 4'd0) begin
      if (start_i) run_cnt <= 4'd1;
    end else if (run_cnt == 4'd9) begin
      run_cnt <= 4'd0;
    end else begin
      run_cnt <= run_cnt + 4'd1;
    end
  end

  assert_done_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == 4'd9) |=> done_o);

  assert_done_only_when_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(run_cnt == 4'd9));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(win_en_o) && $stable(head_en_o) && $stable(valid_o)));

  assert_err_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (win_en_o == '0 && head_en_o == '0 && win_head_o == '0 && !valid_o));

  assert_err_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error_o == (err_flags_o != 4'd0));

  assert_head_prefix_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((head_en_o & (head_en_o + 1'b1)) == '0));

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      assert_win_on_live_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
        win_en_o[w] |-> head_en_o[win_head_o[w*HEAD_IDX_W +: HEAD_IDX_W]]);
    end
  endgenerate

endmodule

bind win_head_resolver whr_checker #(
  .NUM_WIN    (NUM_WIN),
  .HEAD_BITS  (HEAD_BITS),
  .HEAD_IDX_W (HEAD_IDX_W)
) u_whr_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .done_o      (done_o),
  .valid_o     (valid_o),
  .error_o     (error_o),
  .err_flags_o (err_flags_o),
  .win_en_o    (win_en_o),
  .win_head_o  (win_head_o),
  .head_en_o   (head_en_o)
);

// File: tb/win_head_resolver_tb_top.sv
module win_head_resolver_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        mask_present_i = 1'b0;
  logic [63:0] assign_mask_i = '0;
  logic [3:0]  hw_win_count_i = '0;
  logic [3:0]  hw_head_count_i = '0;
  logic        done_o, valid_o, error_o;
  logic [3:0]  err_flags_o;
  logic [7:0]  win_en_o;
  logic [23:0] win_head_o;
  logic [7:0]  head_en_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  win_head_resolver dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .mask_present_i  (mask_present_i),
    .assign_mask_i   (assign_mask_i),
    .hw_win_count_i  (hw_win_count_i),
    .hw_head_count_i (hw_head_count_i),
    .done_o          (done_o),
    .valid_o         (valid_o),
    .error_o         (error_o),
    .err_flags_o     (err_flags_o),
    .win_en_o        (win_en_o),
    .win_head_o      (win_head_o),
    .head_en_o       (head_en_o)
  );

  task automatic check(string req, longint actual, longint expected);
    n_vec++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  // Independent reference model of the requirements
  task automatic model(input logic [63:0] m, input bit present, input int hw_w, input int hw_h,
                       output logic v, output logic e, output logic [3:0] ef,
                       output logic [7:0] we, output logic [23:0] wh, output logic [7:0] he);
    logic [7:0] occ = '0;
    logic [7:0] asg = '0;
    int hd [8];
    logic [63:0] eff = '0;
    bit run;
    ef = '0;
    for (int w = 0; w < 8; w++) begin
      logic [7:0] b;
      int cnt;
      bit badh;
      hd[w] = 0;
      if (present) b = m[w*8 +: 8];
      else b = (w < hw_w && (w / 2) < hw_h) ? (8'd1 << (w / 2)) : 8'd0;
      eff[w*8 +: 8] = b;
      if (b != 0) begin
        if (w >= hw_w) ef[1] = 1'b1;
        else begin
          cnt = 0; badh = 0;
          for (int h = 0; h < 8; h++) if (b[h]) begin
            cnt++;
            if (h >= hw_h) badh = 1;
            hd[w] = h;
          end
          if (cnt > 1) ef[3] = 1'b1;
          if (badh) ef[2] = 1'b1;
          if (cnt == 1 && !badh) begin
            asg[w] = 1'b1;
            occ[hd[w]] = 1'b1;
          end
        end
      end
    end
    if (eff == 0) ef[0] = 1'b1;
    run = 1;
    for (int h = 0; h < 8; h++) begin
      run = run && occ[h] && (h < hw_h);
      he[h] = run;
    end
    we = '0; wh = '0;
    for (int w = 0; w < 8; w++) begin
      if (asg[w] && he[hd[w]]) begin
        we[w] = 1'b1;
        wh[w*3 +: 3] = 3'(hd[w]);
      end
    end
    e = (ef != 0);
    v = !e;
    if (e) begin
      we = '0; wh = '0; he = '0;
    end
  endtask

  task automatic compare_result(string req, logic [63:0] m, bit present, int hw_w, int hw_h);
    logic v, e;
    logic [3:0] ef;
    logic [7:0] we, he;
    logic [23:0] wh;
    model(m, present, hw_w, hw_h, v, e, ef, we, wh, he);
    check({req, " valid"}, valid_o, v);
    check({req, " error"}, error_o, e);
    check({req, " err_flags"}, err_flags_o, ef);
    check({req, " win_en"}, win_en_o, we);
    check({req, " win_head"}, win_head_o, wh);
    check({req, " head_en"}, head_en_o, he);
  endtask

  // Issue a start and verify done lands on the 9th edge (R2); called at a negedge
  task automatic run(string req, logic [63:0] m, bit present, int hw_w, int hw_h);
    assign_mask_i   = m;
    mask_present_i  = present;
    hw_win_count_i  = 4'(hw_w);
    hw_head_count_i = 4'(hw_h);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 1; i <= 9; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i < 9 && done_o) check({req, " R2 early done"}, done_o, 0);
    end
    check({req, " R2 done on 9th edge"}, done_o, 1);
    compare_result(req, m, present, hw_w, hw_h);
    @(posedge clk);
    @(negedge clk);
    check({req, " R2 done pulse width"}, done_o, 0);
  endtask

  task automatic t_reset;
    check("R11 done", done_o, 0);
    check("R11 valid", valid_o, 0);
    check("R11 error", error_o, 0);
    check("R11 outputs", {err_flags_o, win_en_o, win_head_o, head_en_o}, 0);
  endtask

  task automatic t_layout;
    run("R1 R8 explicit mask", 64'h0000_0000_0201_0101, 1, 8, 4);
    check("R1 window3 head", win_head_o[11:9], 1);
    check("R1 window3 enabled", win_en_o[3], 1);
  endtask

  task automatic t_default;
    run("R3 default full", 64'h0, 0, 8, 4);
    check("R3 all windows", win_en_o, 8'hFF);
    run("R3 default partial", 64'h0, 0, 5, 2);
    check("R3 heads 0 and 1", head_en_o, 8'h03);
  endtask

  task automatic t_cull;
    run("R8 R9 cull from empty head", 64'h0000_0000_0000_0401, 1, 8, 3);
    check("R9 still valid", valid_o, 1);
    check("R8 only head0", head_en_o, 8'h01);
    run("R8 high windows cull", 64'h0200_0000_0000_0001, 1, 8, 8);
  endtask

  task automatic t_errors;
    run("R4 R10 unsupported window", 64'h0000_0100_0000_0001, 1, 4, 4);
    check("R4 flag", err_flags_o, 4'b0010);
    run("R5 R10 unsupported head", 64'h0000_0000_0000_0104, 1, 8, 2);
    check("R5 flag", err_flags_o, 4'b0100);
    run("R6 R10 multi head", 64'h0000_0000_0000_0003, 1, 8, 4);
    check("R6 flag", err_flags_o, 4'b1000);
    run("R7 R10 empty mask", 64'h0, 1, 8, 4);
    check("R7 flag", err_flags_o, 4'b0001);
    run("R5 R6 combined", 64'h0000_0000_0000_0005, 1, 8, 2);
    run("R7 default with no windows", 64'h0, 0, 0, 4);
  endtask

  task automatic t_busy_start;
    logic [63:0] m = 64'h0000_0000_0008_0402;
    assign_mask_i = m; mask_present_i = 1; hw_win_count_i = 8; hw_head_count_i = 4;
    start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    for (int i = 1; i <= 9; i++) begin
      if (i == 4) begin
        start_i = 1'b1;
        assign_mask_i = 64'h0;
      end else begin
        start_i = 1'b0;
      end
      @(posedge clk); @(negedge clk);
    end
    start_i = 1'b0;
    check("R2 done with busy start", done_o, 1);
    compare_result("R2 busy start ignored", m, 1, 8, 4);
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); @(negedge clk);
      if (done_o) check("R2 no extra done", done_o, 0);
    end
    assign_mask_i = 64'hFFFF_FFFF_FFFF_FFFF; hw_head_count_i = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    compare_result("R2 result holds", m, 1, 8, 4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_default();
    t_cull();
    t_errors();
    t_busy_start();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule